// File: doc/BRIEF.md
# Synchronous FIFO Controller with Programmable Level Flags

This block is a single-clock first-in first-out buffer whose storage depth is a parameter. It offers two output timing modes, both chosen at reset. In fall-through mode the head word is pushed into an output register on its own and is held there until the consumer takes it. In standard mode the consumer must request every word, and the word arrives one cycle after the request. Alongside the data path the block drives full, half-full, almost-empty and almost-full level flags. It also drives one output status pin whose meaning depends on the timing mode.

The almost-empty and almost-full thresholds start from one of eight preset offset pairs picked at reset. Software can then overwrite them, either as whole words (parallel) or one bit per clock (serial), and can read them back through the same offset port. A reset-time configuration bit picks the flag timing. In immediate timing the flags follow the current occupancy in the same cycle. In registered timing they lag the occupancy by one clock.

The write side is a valid/ready stream. A word is accepted on a rising edge where `wr_valid` and `wr_ready` are both high, and `wr_ready` is low exactly when the buffer holds `DEPTH` words. The producer may hold `wr_valid` high while `wr_ready` is low; nothing is stored until `wr_ready` returns.

The read side depends on the timing mode:
- **Fall-through mode:** `out_valid`/`out_ready` form a normal stream. `out_data` is held stable while `out_valid` is high and `out_ready` is low.
- **Standard mode:** `out_ready` is a read request. `out_valid` is a one-cycle strobe that qualifies `out_data` on the cycle after an accepted request.

Top module: `pff_top`

## Requirements
- R1: The timing mode (`cfg_fwft`), the flag timing (`cfg_flag_reg`), the preset (`cfg_preset`) and the offset-load style (`cfg_ser_load`) are sampled only while `rst_n` is low. Changing these inputs after reset has no effect.
- R2: In fall-through mode, a word written into an empty buffer at rising edge E sets `out_valid` with that word on `out_data` after edge E+2, with no read action. The word then stays there, unchanged, until a rising edge with `out_ready` high removes it.
- R3: In standard mode, a rising edge where `out_ready` is high and a word is available delivers the head word on `out_data` with `out_valid` high for exactly the following cycle. A request made while no word is available is ignored.
- R4: In fall-through mode `out_stat` equals `out_valid`. In standard mode `out_stat` is an active-low empty flag: it is high when a read request would deliver a word, and a newly written word makes it high after the second rising edge from the write.
- R5: `wr_ready` is low when the occupancy equals `DEPTH`. A write attempted at that time is dropped and never appears at the output.
- R6: Occupancy counts the words written and not yet removed by the consumer, including a word held in the fall-through output register. The flags follow from it as follows: `flag_ae` = occupancy ≤ empty offset; `flag_af` = (`DEPTH` − occupancy) ≤ full offset; `flag_half` = occupancy > `DEPTH`/2; `flag_full` = occupancy == `DEPTH`.
- R7: After reset, both offsets equal min((`cfg_preset`+1)·`DEPTH`/16, `DEPTH`−1).
- R8: With parallel loading, each rising edge with `off_wr` high stores `off_pdata`. The first store after reset goes to the empty offset and the stores then alternate between the empty and the full offset.
- R9: With serial loading, each rising edge with `off_wr` high shifts one bit of `off_sdata` into the offsets. The bits go least significant first: all bits of the empty offset first, then all bits of the full offset, and then the sequence wraps around.
- R10: Each rising edge with `off_rd` high places one offset on `off_q` for the next cycle. The first read after reset returns the empty offset and reads then alternate between the two.
- R11: With `cfg_flag_reg` = 0 the flags reflect the occupancy after the same edge that changed it. With `cfg_flag_reg` = 1 they show it one rising edge later.
- R12: Words leave the buffer in the order they were accepted, in both timing modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Synchronous active-low master reset; configuration inputs are sampled while it is low |
| cfg_fwft | input | 1 | 1 selects fall-through timing, 0 selects standard timing |
| cfg_flag_reg | input | 1 | 1 selects registered flag timing, 0 selects immediate |
| cfg_preset | input | 3 | Preset offset pair index |
| cfg_ser_load | input | 1 | 1 selects serial offset loading, 0 selects parallel |
| wr_valid | input | 1 | Write data valid |
| wr_ready | output | 1 | Buffer can accept a word |
| wr_data | input | W | Write data |
| out_valid | output | 1 | Output word valid (stream flag or read strobe, by mode) |
| out_ready | input | 1 | Consumer accepts (fall-through) or read request (standard) |
| out_data | output | W | Output word |
| out_stat | output | 1 | Output ready (fall-through) or empty, active low (standard) |
| flag_full | output | 1 | Occupancy equals DEPTH |
| flag_half | output | 1 | Occupancy above DEPTH/2 |
| flag_ae | output | 1 | Almost empty |
| flag_af | output | 1 | Almost full |
| off_wr | input | 1 | Offset load strobe |
| off_pdata | input | AW | Parallel offset value |
| off_sdata | input | 1 | Serial offset bit |
| off_rd | input | 1 | Offset read-back strobe |
| off_q | output | AW | Read-back offset value |

## Verification
The assertions check, on every cycle, the following properties:
- A fall-through word is held stable until it is accepted.
- A standard-mode strobe only follows a granted request.
- Write-ready drops whenever the immediate full flag is high.
- Registered flags trail the occupancy by exactly one edge.

Only the bench's scenarios can show the rest: the three-edge fall-through latency, the flag thresholds at every occupancy for every preset, the load order and bit order of parallel and serial offset loads with their read-back, data ordering, and the dropping of a write at full.

// File: rtl/pff_pkg.sv
package pff_pkg;

  // Preset offset value for index sel: evenly spaced sixteenths of the depth,
  // capped so that it never reaches the full depth.
  function automatic int unsigned preset_offset(input int unsigned sel,
                                                input int unsigned depth);
    int unsigned v;
    v = ((sel + 1) * depth) / 16;
    if (v > depth - 1) v = depth - 1;
    return v;
  endfunction

  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;

endpackage

// File: rtl/pff_store.sv
module pff_store #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         take,
  output logic [W-1:0] rdata,
  output logic         avail
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          pend;
  logic [CW-1:0] vis;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      pend <= 1'b0;
      vis  <= '0;
    end else begin
      pend <= push;
      if (push) wptr <= wptr + 1'b1;
      if (take) rptr <= rptr + 1'b1;
      vis <= vis + CW'(pend) - CW'(take);
    end
  end

  assign rdata = mem[rptr];
  assign avail = (vis != '0);
endmodule

// File: rtl/pff_outstage.sv
module pff_outstage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fwft,
  input  logic         avail,
  input  logic [W-1:0] rdata,
  input  logic         rd_req,
  output logic         take,
  output logic         deliver,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic ov;

  always_comb begin
    if (fwft) begin
      deliver = ov && rd_req;
      take    = avail && (!ov || deliver);
    end else begin
      take    = rd_req && avail;
      deliver = take;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov       <= 1'b0;
      out_data <= '0;
    end else begin
      if (fwft) begin
        if (take)         ov <= 1'b1;
        else if (deliver) ov <= 1'b0;
      end else begin
        ov <= take;
      end
      if (take) out_data <= rdata;
    end
  end

  assign out_valid = ov;
endmodule

// File: rtl/pff_flags.sv
module pff_flags #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          freg,
  input  logic [CW-1:0] occ,
  input  logic [AW-1:0] ae_off,
  input  logic [AW-1:0] af_off,
  output logic          full,
  output logic          half,
  output logic          ae,
  output logic          af
);
  logic [CW-1:0] free_sp;
  logic c_full, c_half, c_ae, c_af;
  logic r_full, r_half, r_ae, r_af;

  always_comb begin
    free_sp = CW'(DEPTH) - occ;
    c_full  = (occ == CW'(DEPTH));
    c_half  = (occ > CW'(DEPTH / 2));
    c_ae    = (occ <= {1'b0, ae_off});
    c_af    = (free_sp <= {1'b0, af_off});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_full <= 1'b0;
      r_half <= 1'b0;
      r_ae   <= 1'b1;
      r_af   <= 1'b0;
    end else begin
      r_full <= c_full;
      r_half <= c_half;
      r_ae   <= c_ae;
      r_af   <= c_af;
    end
  end

  assign full = freg ? r_full : c_full;
  assign half = freg ? r_half : c_half;
  assign ae   = freg ? r_ae   : c_ae;
  assign af   = freg ? r_af   : c_af;
endmodule

// File: rtl/pff_offsets.sv
module pff_offsets #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int SCW  = $clog2(2 * AW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    preset,
  input  logic          ser,
  input  logic          wr,
  input  logic [AW-1:0] pdata,
  input  logic          sdata,
  input  logic          rd,
  output logic [AW-1:0] ae_off,
  output logic [AW-1:0] af_off,
  output logic [AW-1:0] rdq
);
  import pff_pkg::*;

  logic           wsel, rsel;
  logic [SCW-1:0] sc;
  logic [AW-1:0]  pre_val;

  assign pre_val = AW'(preset_offset(int'(unsigned'(preset)), DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ae_off <= pre_val;
      af_off <= pre_val;
      wsel   <= 1'b0;
      rsel   <= 1'b0;
      sc     <= '0;
      rdq    <= '0;
    end else begin
      if (wr) begin
        if (ser) begin
          for (int i = 0; i < AW; i++) begin
            if (sc == SCW'(i))      ae_off[i] <= sdata;
            if (sc == SCW'(i + AW)) af_off[i] <= sdata;
          end
          sc <= (sc == SCW'(2 * AW - 1)) ? '0 : sc + 1'b1;
        end else begin
          if (!wsel) ae_off <= pdata;
          else       af_off <= pdata;
          wsel <= ~wsel;
        end
      end
      if (rd) begin
        rdq  <= rsel ? af_off : ae_off;
        rsel <= ~rsel;
      end
    end
  end
endmodule

// File: rtl/pff_top.sv
module pff_top #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_fwft,
  input  logic          cfg_flag_reg,
  input  logic [2:0]    cfg_preset,
  input  logic          cfg_ser_load,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [W-1:0]  wr_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic          out_stat,
  output logic          flag_full,
  output logic          flag_half,
  output logic          flag_ae,
  output logic          flag_af,
  input  logic          off_wr,
  input  logic [AW-1:0] off_pdata,
  input  logic          off_sdata,
  input  logic          off_rd,
  output logic [AW-1:0] off_q
);
  import pff_pkg::*;

  rd_mode_e      mode_q;
  logic          freg_q, ser_q;
  logic          fwft_q;
  logic [CW-1:0] occ;
  logic          push, take, deliver, avail;
  logic [W-1:0]  rdata;
  logic [AW-1:0] ae_off, af_off;

  // Configuration is captured only while the master reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= cfg_fwft ? RD_FWFT : RD_STD;
      freg_q <= cfg_flag_reg;
      ser_q  <= cfg_ser_load;
    end
  end
  assign fwft_q = (mode_q == RD_FWFT);

  assign wr_ready = (occ != CW'(DEPTH));
  assign push     = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + CW'(push) - CW'(deliver);
  end

  pff_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(wr_data),
    .take(take), .rdata(rdata), .avail(avail)
  );

  pff_outstage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .fwft(fwft_q), .avail(avail), .rdata(rdata),
    .rd_req(out_ready), .take(take), .deliver(deliver),
    .out_valid(out_valid), .out_data(out_data)
  );

  pff_offsets #(.DEPTH(DEPTH)) u_offs (
    .clk(clk), .rst_n(rst_n), .preset(cfg_preset), .ser(ser_q),
    .wr(off_wr), .pdata(off_pdata), .sdata(off_sdata), .rd(off_rd),
    .ae_off(ae_off), .af_off(af_off), .rdq(off_q)
  );

  pff_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .freg(freg_q), .occ(occ),
    .ae_off(ae_off), .af_off(af_off),
    .full(flag_full), .half(flag_half), .ae(flag_ae), .af(flag_af)
  );

  assign out_stat = fwft_q ? out_valid : avail;
endmodule

// File: rtl/pff_chk.sv
module pff_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fwft_q,
  input logic         freg_q,
  input logic         wr_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_stat,
  input logic         flag_full
);
  // R2: a presented fall-through word holds until accepted
  a_r2_fwft_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft_q && out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R3: a standard-mode strobe follows a request that found a word
  a_r3_std_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft_q && out_valid) |-> ($past(out_ready) && $past(out_stat)));

  // R3: a standard-mode request with nothing available yields no strobe
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft_q && out_ready && !out_stat) |=> !out_valid);

  // R5: immediate full flag blocks writes
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!freg_q && flag_full) |-> !wr_ready);

  // R11: registered full flag trails the write-side fullness by one edge
  a_r11_reg_lag: assert property (@(posedge clk) disable iff (!rst_n)
    freg_q |=> (flag_full == $past(!wr_ready)));
endmodule

bind pff_top pff_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fwft_q(fwft_q), .freg_q(freg_q),
  .wr_ready(wr_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_stat(out_stat), .flag_full(flag_full)
);

// File: tb/tb_pff_top.sv
module tb_pff_top;
  localparam int W = 8;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_fwft = 1'b0, cfg_flag_reg = 1'b0, cfg_ser_load = 1'b0;
  logic [2:0] cfg_preset = '0;
  logic wr_valid = 1'b0, out_ready = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic off_wr = 1'b0, off_sdata = 1'b0, off_rd = 1'b0;
  logic [AW-1:0] off_pdata = '0;
  logic wr_ready, out_valid, out_stat, flag_full, flag_half, flag_ae, flag_af;
  logic [W-1:0] out_data;
  logic [AW-1:0] off_q;

  int n_chk = 0;
  int n_bad = 0;

  pff_top #(.W(W), .DEPTH(DEPTH)) dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input bit fw, input bit fr, input int p, input bit sr);
    rst_n = 1'b0;
    cfg_fwft = fw; cfg_flag_reg = fr; cfg_preset = 3'(p); cfg_ser_load = sr;
    wr_valid = 0; out_ready = 0; off_wr = 0; off_rd = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    // R1: flip configuration pins after reset; must have no effect
    cfg_fwft = ~fw; cfg_flag_reg = ~fr; cfg_ser_load = ~sr; cfg_preset = ~cfg_preset;
  endtask

  task automatic push(input logic [W-1:0] d);
    wr_valid = 1'b1; wr_data = d;
    tick();
    wr_valid = 1'b0;
  endtask

  function automatic int poff(input int p);
    int v;
    v = ((p + 1) * DEPTH) / 16;
    if (v > DEPTH - 1) v = DEPTH - 1;
    return v;
  endfunction

  task automatic chk_flags(input string tag, input int n, input int e, input int f);
    chk({tag, " R6 ae"},   int'(flag_ae),   int'(n <= e));
    chk({tag, " R6 af"},   int'(flag_af),   int'((DEPTH - n) <= f));
    chk({tag, " R6 half"}, int'(flag_half), int'(n > DEPTH / 2));
    chk({tag, " R6 full"}, int'(flag_full), int'(n == DEPTH));
  endtask

  // Remove one word in either mode; returns the data seen.
  task automatic pop(input bit fw, output logic [W-1:0] d);
    if (fw) begin
      for (int k = 0; k < 6 && !out_valid; k++) tick();
      d = out_data;
      out_ready = 1'b1; tick(); out_ready = 1'b0;
    end else begin
      for (int k = 0; k < 6 && !out_stat; k++) tick();
      out_ready = 1'b1; tick(); out_ready = 1'b0;
      chk("R3 strobe", int'(out_valid), 1);
      d = out_data;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] d;

    // Reset state and fall-through latency (R1, R2, R4, R7)
    do_reset(1, 0, 0, 0);
    chk("reset wr_ready", int'(wr_ready), 1);
    chk("reset out_stat", int'(out_stat), 0);
    chk("reset R6 ae", int'(flag_ae), 1);
    chk("reset R6 full", int'(flag_full), 0);
    push(8'hA5);
    chk("R2 not yet after write edge", int'(out_valid), 0);
    tick();
    chk("R2 not yet after edge+1", int'(out_valid), 0);
    chk("R1 mode kept", int'(out_stat), 0);
    tick();
    chk("R2 valid after edge+2", int'(out_valid), 1);
    chk("R2 data", int'(out_data), 8'hA5);
    chk("R4 fwft stat", int'(out_stat), 1);
    tick(); tick();
    chk("R2 hold valid", int'(out_valid), 1);
    chk("R2 hold data", int'(out_data), 8'hA5);
    out_ready = 1; tick(); out_ready = 0;
    chk("R2 removed", int'(out_valid), 0);

    // Standard mode (R3, R4)
    do_reset(0, 0, 0, 0);
    out_ready = 1; tick(); out_ready = 0;
    chk("R3 empty request ignored", int'(out_valid), 0);
    push(8'h3C);
    chk("R4 empty after write edge", int'(out_stat), 0);
    tick();
    chk("R4 not empty after edge+1", int'(out_stat), 1);
    chk("R3 no strobe w/o request", int'(out_valid), 0);
    out_ready = 1; tick(); out_ready = 0;
    chk("R3 strobe", int'(out_valid), 1);
    chk("R3 data", int'(out_data), 8'h3C);
    tick();
    chk("R3 one-cycle strobe", int'(out_valid), 0);
    chk("R4 empty again", int'(out_stat), 0);

    // Flag timing (R11) with preset 0: offsets = 1
    for (int fr = 0; fr < 2; fr++) begin
      do_reset(0, fr[0], 0, 0);
      push(8'h01);
      push(8'h02);
      chk("R11 ae right after edge", int'(flag_ae), fr == 0 ? 0 : 1);
      tick();
      chk("R11 ae one edge later", int'(flag_ae), 0);
    end

    // Sweep: every preset, both modes, every occupancy (R5, R6, R7, R12)
    for (int p = 0; p < 8; p++) begin
      bit fw;
      bit fr;
      int e;
      fw = p[0]; fr = p[1];
      e = poff(p);
      do_reset(fw, fr, p, 0);
      tick();
      chk_flags("R7 sweep n=0", 0, e, e);
      for (int n = 1; n <= DEPTH; n++) begin
        push(8'(p * 32 + n));
        tick(); tick();
        chk_flags("R7 sweep fill", n, e, e);
      end
      chk("R5 wr_ready at full", int'(wr_ready), 0);
      push(8'hEE);
      for (int n = DEPTH - 1; n >= 0; n--) begin
        pop(fw, d);
        chk("R12 order", int'(d), (p * 32 + DEPTH - n) & 8'hFF);
        tick(); tick();
        chk_flags("R6 sweep drain", n, e, e);
      end
      repeat (4) tick();
      chk("R5 dropped write absent stat", int'(out_stat), 0);
      chk("R5 dropped write absent valid", int'(out_valid), 0);
    end

    // Parallel load and read-back (R8, R10)
    do_reset(0, 0, 7, 0);
    off_wr = 1; off_pdata = 4'd3; tick();
    off_pdata = 4'd12; tick(); off_wr = 0;
    off_rd = 1; tick();
    chk("R10 first read empty off", int'(off_q), 3);
    tick(); off_rd = 0;
    chk("R10 second read full off", int'(off_q), 12);
    for (int n = 1; n <= 4; n++) push(8'(n));
    chk_flags("R8 loaded n=4", 4, 3, 12);
    out_ready = 1; tick(); out_ready = 0;
    chk_flags("R8 loaded n=3", 3, 3, 12);

    // Serial load and read-back (R9, R10): empty=5, full=9, LSB first
    do_reset(0, 0, 0, 1);
    off_wr = 1;
    foreach (d[i]) if (i < 0) d = 0;
    for (int i = 0; i < AW; i++) begin off_sdata = 1'((5 >> i) & 1); tick(); end
    for (int i = 0; i < AW; i++) begin off_sdata = 1'((9 >> i) & 1); tick(); end
    off_wr = 0;
    off_rd = 1; tick();
    chk("R9 serial empty off", int'(off_q), 5);
    tick(); off_rd = 0;
    chk("R9 serial full off", int'(off_q), 9);
    for (int n = 1; n <= 5; n++) push(8'(n));
    chk_flags("R9 serial n=5", 5, 5, 9);
    push(8'd6); push(8'd7);
    chk_flags("R9 serial n=7", 7, 5, 9);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule